// File: doc/BRIEF.md
# Four-Mode Power Management Controller

This block selects and gates the clocks of a small microcontroller according to one of four power modes: Active, Power Save, Idle and Halt. It takes a fast clock and a slow clock, each with a stability flag. It produces a gated system clock, a gated timer/watchdog clock, an enable for the fast oscillator and the current mode code.

Software moves the block toward lower power by writing a mode code on a write port that is synchronous to the slow clock. A wake-up event returns the block to Active in hardware. The mode logic runs on the slow clock, so it keeps working in every mode. Each clock output passes through a glitch-free gate. That gate brings its request into the clock's own domain with a two-flop synchronizer and applies it on the falling edge. The two sources of the system clock interlock, so one is fully off before the other turns on.

While reset is held, the system clock output follows the source chosen for reset, but only when that source is flagged stable.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset is released, `mode_o` reads 2'b00 (Active) and `hf_osc_en_o` is 1.
- R2: The mode codes are Active=00, Power Save=01, Idle=10, Halt=11. In Active, the system clock comes from the fast clock and the timer clock comes from the slow clock. In Power Save, both clocks come from the slow clock. The two sources never drive the system clock at the same time.
- R3: In Idle, the system clock is held low and the timer clock keeps running on the slow clock.
- R4: In Halt, the system clock and the timer clock are both held low, and `hf_osc_en_o` is 0.
- R5: A write takes effect on the slow-clock edge that samples `wr_en_i`, but only in two cases: the written code is numerically higher than the current one (a lower-power mode), or Active (00) is written while in Power Save. Every other write is ignored and leaves the mode unchanged.
- R6: A wake-up event (any bit of `wake_i` high) returns the block to Active from any mode within three slow-clock edges. While a wake-up event is present, it takes priority over a write.
- R7: In Power Save and Idle, `hf_osc_en_o` equals the inverse of the last accepted `wr_hf_off_i`, but only while the slow clock is stable. While the slow clock is unstable, `hf_osc_en_o` is 1.
- R8: While a source's stability flag is 0, no output driven from that source toggles.
- R9: While reset is held, the system clock follows the source chosen for reset (fast by default) when that source is stable, and stays low otherwise.
- R10: After waking while the fast clock is unstable, the system clock stays low. It starts on the fast clock once that clock's stability flag rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hf_clk_i | input | 1 | Fast clock |
| lf_clk_i | input | 1 | Slow clock, also the clock of the mode logic |
| hf_stable_i | input | 1 | Fast clock is stable |
| lf_stable_i | input | 1 | Slow clock is stable |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Mode register write strobe, synchronous to the slow clock |
| wr_mode_i | input | 2 | Requested mode code |
| wr_hf_off_i | input | 1 | Request to stop the fast oscillator in Power Save or Idle |
| wake_i | input | WAKE_W | Wake-up event lines, level sensitive |
| sys_clk_o | output | 1 | Gated system clock |
| tmr_clk_o | output | 1 | Gated timer/watchdog clock |
| hf_osc_en_o | output | 1 | Fast oscillator enable |
| mode_o | output | 2 | Current mode code |

## Verification
The assertions take several things for granted about the inputs:
- Write strobes are one slow-clock cycle wide and aligned to that clock.
- Mode changes are spaced far enough apart for the fast-domain synchronizer to drain.
- A stability flag that is low stays low across whole cycles of its own clock.

The stimulus keeps to these limits. It drives writes on slow-clock falling edges and holds each wake-up pulse for several slow cycles. It changes stability flags only between settling periods. It then measures each clock output by counting its edges over a fixed window, instead of sampling it at a single instant.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    MODE_ACT = 2'b00,
    MODE_PSV = 2'b01,
    MODE_IDL = 2'b10,
    MODE_HLT = 2'b11
  } pmode_e;
endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) q[i] <= '0;
    end else begin
      q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) q[i] <= q[i-1];
    end
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/pmc_clk_gate.sv
module pmc_clk_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic stable_i,
  output logic en_o,
  output logic gclk_o
);
  logic req_s;
  logic en_q;

  pmc_sync #(.STAGES(SYNC_STAGES), .W(1)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_i),
    .q_o   (req_s)
  );

  // enable changes only while the clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= req_s & stable_i;
  end

  assign en_o   = en_q;
  assign gclk_o = clk_i & en_q;
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pmc_pkg::*;
#(
  parameter int WAKE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              lf_clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_mode_i,
  input  logic              wr_hf_off_i,
  input  logic [WAKE_W-1:0] wake_i,
  input  logic              hf_stable_i,
  input  logic              lf_stable_i,
  output pmode_e            mode_o,
  output logic              hf_sys_req_o,
  output logic              lf_sys_req_o,
  output logic              tmr_req_o,
  output logic              hf_osc_en_o
);
  pmode_e mode_q;
  logic   hf_off_q;
  logic   wake_s, hf_st_s, lf_st_s;
  pmode_e wr_mode;
  logic   wr_ok;

  pmc_sync #(.STAGES(SYNC_STAGES), .W(3)) i_sync (
    .clk_i (lf_clk_i),
    .rst_ni(rst_ni),
    .d_i   ({|wake_i, hf_stable_i, lf_stable_i}),
    .q_o   ({wake_s, hf_st_s, lf_st_s})
  );

  assign wr_mode = pmode_e'(wr_mode_i);
  assign wr_ok   = wr_en_i &&
                   ((wr_mode > mode_q) || (mode_q == MODE_PSV && wr_mode == MODE_ACT));

  always_ff @(posedge lf_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_ACT;
      hf_off_q <= 1'b0;
    end else if (wake_s) begin
      mode_q <= MODE_ACT;
    end else if (wr_ok) begin
      mode_q   <= wr_mode;
      hf_off_q <= wr_hf_off_i;
    end
  end

  always_comb begin
    case (mode_q)
      MODE_ACT: hf_osc_en_o = 1'b1;
      MODE_HLT: hf_osc_en_o = 1'b0;
      default:  hf_osc_en_o = !(hf_off_q && lf_st_s);
    endcase
  end

  assign mode_o       = mode_q;
  assign hf_sys_req_o = (mode_q == MODE_ACT) && hf_st_s;
  assign lf_sys_req_o = (mode_q == MODE_PSV);
  assign tmr_req_o    = (mode_q != MODE_HLT);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int WAKE_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter bit RST_SRC_LF  = 1'b0
) (
  input  logic              hf_clk_i,
  input  logic              lf_clk_i,
  input  logic              hf_stable_i,
  input  logic              lf_stable_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_mode_i,
  input  logic              wr_hf_off_i,
  input  logic [WAKE_W-1:0] wake_i,
  output logic              sys_clk_o,
  output logic              tmr_clk_o,
  output logic              hf_osc_en_o,
  output logic [1:0]        mode_o
);
  pmode_e mode;
  logic   hf_sys_req, lf_sys_req, tmr_req;
  logic   hf_sys_en, lf_sys_en, tmr_en;
  logic   hf_gclk, lf_gclk, tmr_gclk;
  logic   rst_clk;

  pmc_mode_fsm #(.WAKE_W(WAKE_W), .SYNC_STAGES(SYNC_STAGES)) i_fsm (
    .lf_clk_i    (lf_clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_mode_i   (wr_mode_i),
    .wr_hf_off_i (wr_hf_off_i),
    .wake_i      (wake_i),
    .hf_stable_i (hf_stable_i),
    .lf_stable_i (lf_stable_i),
    .mode_o      (mode),
    .hf_sys_req_o(hf_sys_req),
    .lf_sys_req_o(lf_sys_req),
    .tmr_req_o   (tmr_req),
    .hf_osc_en_o (hf_osc_en_o)
  );

  // each system source waits for the other's enable to drop
  pmc_clk_gate #(.SYNC_STAGES(SYNC_STAGES)) i_gate_hf (
    .clk_i   (hf_clk_i),
    .rst_ni  (rst_ni),
    .req_i   (hf_sys_req & ~lf_sys_en),
    .stable_i(hf_stable_i),
    .en_o    (hf_sys_en),
    .gclk_o  (hf_gclk)
  );

  pmc_clk_gate #(.SYNC_STAGES(SYNC_STAGES)) i_gate_lf (
    .clk_i   (lf_clk_i),
    .rst_ni  (rst_ni),
    .req_i   (lf_sys_req & ~hf_sys_en),
    .stable_i(lf_stable_i),
    .en_o    (lf_sys_en),
    .gclk_o  (lf_gclk)
  );

  pmc_clk_gate #(.SYNC_STAGES(SYNC_STAGES)) i_gate_tmr (
    .clk_i   (lf_clk_i),
    .rst_ni  (rst_ni),
    .req_i   (tmr_req),
    .stable_i(lf_stable_i),
    .en_o    (tmr_en),
    .gclk_o  (tmr_gclk)
  );

  generate
    if (RST_SRC_LF) begin : g_rst_lf
      assign rst_clk = lf_clk_i & lf_stable_i;
    end else begin : g_rst_hf
      assign rst_clk = hf_clk_i & hf_stable_i;
    end
  endgenerate

  assign sys_clk_o = rst_ni ? (hf_gclk | lf_gclk) : rst_clk;
  assign tmr_clk_o = tmr_gclk;
  assign mode_o    = mode;
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker (
  input logic       hf_clk_i,
  input logic       lf_clk_i,
  input logic       rst_ni,
  input logic       hf_stable_i,
  input logic       lf_stable_i,
  input logic       wr_en_i,
  input logic [1:0] wr_mode_i,
  input logic [1:0] mode_o,
  input logic       hf_osc_en_o,
  input logic       hf_sys_en,
  input logic       lf_sys_en,
  input logic       tmr_en
);
  p_one_source_r2: assert property (@(posedge hf_clk_i) disable iff (!rst_ni)
    !(hf_sys_en && lf_sys_en));

  p_idle_sys_off_r3: assert property (@(posedge lf_clk_i) disable iff (!rst_ni)
    (mode_o == 2'b10 && $past(mode_o) == 2'b10 && $past(mode_o, 2) == 2'b10 &&
     $past(mode_o, 3) == 2'b10) |-> (!hf_sys_en && !lf_sys_en));

  p_halt_off_r4: assert property (@(posedge lf_clk_i) disable iff (!rst_ni)
    (mode_o == 2'b11 && $past(mode_o) == 2'b11 && $past(mode_o, 2) == 2'b11 &&
     $past(mode_o, 3) == 2'b11) |-> (!tmr_en && !lf_sys_en && !hf_sys_en && !hf_osc_en_o));

  p_lower_only_r5: assert property (@(posedge lf_clk_i) disable iff (!rst_ni)
    (mode_o != $past(mode_o) && mode_o != 2'b00) |->
      ($past(wr_en_i) && $past(wr_mode_i) == mode_o && mode_o > $past(mode_o)));

  p_hf_unstable_r8: assert property (@(posedge hf_clk_i) disable iff (!rst_ni)
    (!hf_stable_i && !$past(hf_stable_i)) |-> !hf_sys_en);

  p_lf_unstable_r8: assert property (@(posedge lf_clk_i) disable iff (!rst_ni)
    (!lf_stable_i && !$past(lf_stable_i)) |-> (!lf_sys_en && !tmr_en));
endmodule

bind pwr_mode_ctrl pmc_checker i_pmc_checker (
  .hf_clk_i   (hf_clk_i),
  .lf_clk_i   (lf_clk_i),
  .rst_ni     (rst_ni),
  .hf_stable_i(hf_stable_i),
  .lf_stable_i(lf_stable_i),
  .wr_en_i    (wr_en_i),
  .wr_mode_i  (wr_mode_i),
  .mode_o     (mode_o),
  .hf_osc_en_o(hf_osc_en_o),
  .hf_sys_en  (hf_sys_en),
  .lf_sys_en  (lf_sys_en),
  .tmr_en     (tmr_en)
);

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctrl;
  localparam int WAKE_W = 4;
  localparam int K_OFF = 0, K_LF = 1, K_HF = 2, K_BAD = 3;

  logic hf_clk = 0, lf_clk = 0;
  logic hf_stable, lf_stable, rst_n;
  logic wr_en, wr_hf_off;
  logic [1:0] wr_mode;
  logic [WAKE_W-1:0] wake;
  logic sys_clk, tmr_clk, hf_osc_en;
  logic [1:0] mode;

  int n_tests = 0, n_fail = 0;
  int sys_cnt = 0, tmr_cnt = 0;
  int exp_mode;
  bit exp_hf_off;

  always #2  hf_clk = ~hf_clk;
  always #20 lf_clk = ~lf_clk;

  always @(posedge sys_clk) sys_cnt++;
  always @(posedge tmr_clk) tmr_cnt++;

  pwr_mode_ctrl #(.WAKE_W(WAKE_W)) i_pwr_mode_ctrl (
    .hf_clk_i(hf_clk), .lf_clk_i(lf_clk),
    .hf_stable_i(hf_stable), .lf_stable_i(lf_stable),
    .rst_ni(rst_n), .wr_en_i(wr_en), .wr_mode_i(wr_mode),
    .wr_hf_off_i(wr_hf_off), .wake_i(wake),
    .sys_clk_o(sys_clk), .tmr_clk_o(tmr_clk),
    .hf_osc_en_o(hf_osc_en), .mode_o(mode)
  );

  function automatic int classify(int n);
    if (n == 0) return K_OFF;
    if (n >= 10 && n <= 30) return K_LF;
    if (n >= 150) return K_HF;
    return K_BAD;
  endfunction

  function automatic int exp_sys(int m, bit hfs, bit lfs);
    if (m == 0) return hfs ? K_HF : K_OFF;
    if (m == 1) return lfs ? K_LF : K_OFF;
    return K_OFF;
  endfunction

  function automatic int exp_tmr(int m, bit lfs);
    if (m == 3) return K_OFF;
    return lfs ? K_LF : K_OFF;
  endfunction

  function automatic bit exp_osc(int m, bit hoff, bit lfs);
    if (m == 0) return 1'b1;
    if (m == 3) return 1'b0;
    return !(hoff && lfs);
  endfunction

  function automatic bit accepts(int cur, int wm);
    return (wm > cur) || (cur == 1 && wm == 0);
  endfunction

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count output edges over 20 slow cycles
  task automatic measure(output int ks, output int kt);
    #1;
    sys_cnt = 0; tmr_cnt = 0;
    #800;
    ks = classify(sys_cnt);
    kt = classify(tmr_cnt);
  endtask

  task automatic settle();
    repeat (8) @(negedge lf_clk);
  endtask

  task automatic do_write(int m, bit hoff);
    @(negedge lf_clk);
    wr_en = 1; wr_mode = m[1:0]; wr_hf_off = hoff;
    if (accepts(exp_mode, m)) begin exp_mode = m; exp_hf_off = hoff; end
    @(negedge lf_clk);
    wr_en = 0;
  endtask

  task automatic do_wake(logic [WAKE_W-1:0] lines);
    @(negedge lf_clk);
    wake = lines;
    repeat (4) @(negedge lf_clk);
    wake = '0;
    exp_mode = 0;
  endtask

  task automatic check_all(string req);
    int ks, kt;
    settle();
    check({req, " mode"}, mode, exp_mode);
    check({req, " osc"}, hf_osc_en, exp_osc(exp_mode, exp_hf_off, lf_stable));
    measure(ks, kt);
    check({req, " sys"}, ks, exp_sys(exp_mode, hf_stable, lf_stable));
    check({req, " tmr"}, kt, exp_tmr(exp_mode, lf_stable));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge hf_clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    int ks, kt;
    int seed;
    rst_n = 0; hf_stable = 0; lf_stable = 1;
    wr_en = 0; wr_mode = 0; wr_hf_off = 0; wake = '0;
    exp_mode = 0; exp_hf_off = 0;
    seed = 32'h5eed;
    void'($urandom(seed));

    // R9: reset-selected fast source unstable, then stable
    repeat (2) @(negedge lf_clk);
    measure(ks, kt);
    check("R9 unstable in reset", ks, K_OFF);
    hf_stable = 1;
    measure(ks, kt);
    check("R9 stable in reset", ks, K_HF);

    @(negedge lf_clk);
    rst_n = 1;
    settle();
    check("R1 mode", mode, 0);
    check("R1 osc", hf_osc_en, 1);
    check_all("R2 active");

    do_write(1, 1'b1);
    check("R5 write psv", mode, 1);
    check_all("R2 psv R7");

    lf_stable = 0;
    check_all("R8 lf unstable R7");
    lf_stable = 1;
    settle();

    do_write(0, 1'b0);
    check("R5 psv to act", mode, 0);
    check_all("R5 back active");

    do_write(2, 1'b0);
    check_all("R3 idle");
    do_write(1, 1'b0);
    check("R5 idle to psv ignored", mode, 2);
    do_write(0, 1'b0);
    check("R5 idle to act ignored", mode, 2);

    do_write(3, 1'b0);
    check_all("R4 halt");

    hf_stable = 0;
    do_wake(4'b0010);
    check_all("R10 wake hf unstable R6");
    hf_stable = 1;
    check_all("R10 hf now stable");

    hf_stable = 0;
    check_all("R8 hf unstable active");
    hf_stable = 1;
    settle();

    // R6: wake present beats a write
    do_write(2, 1'b1);
    check("R6 idle before wake", mode, 2);
    @(negedge lf_clk);
    wake = 4'b1000;
    repeat (4) @(negedge lf_clk);
    wr_en = 1; wr_mode = 2'd3; wr_hf_off = 0;
    @(negedge lf_clk);
    wr_en = 0;
    check("R6 wake over write", mode, 0);
    wake = '0;
    exp_mode = 0;
    check_all("R6 after wake");

    for (int i = 0; i < 30; i++) begin
      int op;
      op = $urandom_range(0, 3);
      if (op == 0) do_wake(WAKE_W'($urandom_range(1, (1 << WAKE_W) - 1)));
      else do_write($urandom_range(0, 3), 1'($urandom_range(0, 1)));
      check_all("R5 R6 R7 random");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule